// File: doc/BRIEF.md
# Snooze Entry and Exit Controller

This block governs the low-power snooze state of a synchronous memory. An asynchronous, active-high snooze request is first brought into the clock domain. A small state machine then walks through a timed entry phase, a resting phase and a timed recovery phase. Whenever the block is not fully awake, it tells the memory controller to ignore every access input. It also tells the data bus drivers to stay in high impedance. The array contents are not touched, so the stored data survives the nap. Power switching itself is handled elsewhere.

The surrounding logic supplies a single "deselected" indication, which is high when every chip select and every address strobe is inactive. During recovery, the host must keep the device deselected. If it does not, a sticky protocol-error flag is raised, and the offending access stays blocked. Any access still in flight when the snooze request arrives is abandoned: the bus is released as soon as the synchronised request is seen.

Top module: `zz_sleep_ctrl`

## Requirements
- R1: After the active-low asynchronous reset, the block is awake. All four outputs (sleep, mask, bus-off, error) read 0, and they stay 0 while the snooze input is held low.
- R2: The snooze input passes through a two-flop synchroniser. If it is driven high before clock edge n, bus-off rises after edge n+1 and mask rises after edge n+2.
- R3: The entry phase lasts exactly two cycles with mask and bus-off high and sleep low. Sleep rises after edge n+4.
- R4: While asleep and the snooze input stays high, sleep, mask and bus-off all stay high, and the deselected input has no effect.
- R5: If the snooze input is driven low before edge k while asleep, sleep falls after edge k+2. Recovery then lasts two cycles with mask and bus-off high, and mask and bus-off fall after edge k+4.
- R6: If the deselected input is low at an edge taken during recovery, the error output rises after that edge and stays high until reset. Mask stays high for the rest of recovery.
- R7: A low deselected input outside recovery never sets the error output.
- R8: A one-cycle snooze pulse still completes the full sequence: two entry cycles, one sleep cycle, two recovery cycles, then awake.
- R9: Reset taken while asleep or with the error flag set returns the block at once to the awake state with the error flag cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| zz_i | input | 1 | Asynchronous snooze request, active high |
| desel_i | input | 1 | High when all selects and strobes are inactive |
| sleep_o | output | 1 | High while in the resting snooze state |
| mask_o | output | 1 | High when access inputs must be ignored |
| bus_off_o | output | 1 | High when the data bus must be high impedance |
| proto_err_o | output | 1 | Sticky flag: the device was selected during recovery |

## Verification
The assertions assume the snooze request holds its level for at least one clock, so that the synchroniser output is a clean level. They also assume the deselected input is meaningful only as a level sampled at rising edges. The stimulus changes both inputs only on falling edges and holds each level for one or more whole cycles. Reset is asserted and released on falling edges. Pulses as short as one cycle and selection attempts during each phase are exercised, all inside these limits.

// File: rtl/zz_sleep_pkg.sv
package zz_sleep_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_ENTER   = 2'd1,
    ST_SLEEP   = 2'd2,
    ST_RECOVER = 2'd3
  } slp_state_e;
endpackage

// File: rtl/zz_sync.sv
module zz_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/zz_sleep_fsm.sv
module zz_sleep_fsm
  import zz_sleep_pkg::*;
#(
  parameter int ENTER_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       zz_s_i,
  output slp_state_e state_o
);
  localparam int MAXC = (ENTER_CYCLES > EXIT_CYCLES) ? ENTER_CYCLES : EXIT_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ENTER_LD = CW'(ENTER_CYCLES - 1);
  localparam logic [CW-1:0] EXIT_LD  = CW'(EXIT_CYCLES - 1);

  slp_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_ACTIVE: if (zz_s_i) begin
        st_d  = ST_ENTER;
        cnt_d = ENTER_LD;
      end
      ST_ENTER: begin
        if (cnt_q == '0) st_d = ST_SLEEP;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_SLEEP: if (!zz_s_i) begin
        st_d  = ST_RECOVER;
        cnt_d = EXIT_LD;
      end
      ST_RECOVER: begin
        if (cnt_q == '0) st_d = ST_ACTIVE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_ACTIVE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;

  a_r2_leave_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACTIVE && zz_s_i) |=> st_q == ST_ENTER);
  a_r3_enter_to_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ENTER && cnt_q == '0) |=> st_q == ST_SLEEP);
  a_r4_sleep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLEEP && zz_s_i) |=> st_q == ST_SLEEP);
  a_r5_wake_starts_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLEEP && !zz_s_i) |=> st_q == ST_RECOVER);
endmodule

// File: rtl/zz_sleep_err.sv
module zz_sleep_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic recover_i,
  input  logic desel_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    err_q <= 1'b0;
    else if (recover_i && !desel_i) err_q <= 1'b1;
  end

  assign err_o = err_q;

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  a_r6_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recover_i && !desel_i) |=> err_q);
  a_r7_no_err_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!recover_i && !err_q) |=> !err_q);
endmodule

// File: rtl/zz_sleep_ctrl.sv
module zz_sleep_ctrl
  import zz_sleep_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTER_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zz_i,
  input  logic desel_i,
  output logic sleep_o,
  output logic mask_o,
  output logic bus_off_o,
  output logic proto_err_o
);
  logic       zz_s;
  slp_state_e st;

  zz_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (zz_i),
    .q_o   (zz_s)
  );

  zz_sleep_fsm #(.ENTER_CYCLES(ENTER_CYCLES), .EXIT_CYCLES(EXIT_CYCLES)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .zz_s_i (zz_s),
    .state_o(st)
  );

  zz_sleep_err u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .recover_i(st == ST_RECOVER),
    .desel_i  (desel_i),
    .err_o    (proto_err_o)
  );

  assign sleep_o   = (st == ST_SLEEP);
  assign mask_o    = (st != ST_ACTIVE);
  // release the bus as soon as a request is seen; in-flight access is dropped
  assign bus_off_o = mask_o | zz_s;

  a_r5_mask_drops_after_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mask_o) |-> $past(st) == ST_RECOVER);
  a_r4_sleep_rises_from_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> $past(st) == ST_ENTER);
endmodule

// File: tb/zz_sleep_ctrl_test.sv
module zz_sleep_ctrl_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic zz = 1'b0;
  logic desel = 1'b1;
  logic sleep_w, mask_w, busoff_w, err_w;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  zz_sleep_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .zz_i(zz), .desel_i(desel),
    .sleep_o(sleep_w), .mask_o(mask_w), .bus_off_o(busoff_w), .proto_err_o(err_w)
  );

  function automatic void compare(logic [3:0] exp, string tag);
    logic [3:0] act;
    act = {sleep_w, mask_w, busoff_w, err_w};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sleep/mask/busoff/err actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endfunction

  // monitor: sample each result well after the rising edge
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      compare(e.exp, e.tag);
    end
  end

  // driver: apply inputs on falling edge, queue outputs expected after next rise
  task automatic step(input logic z, input logic d, input logic [3:0] exp, input string tag);
    exp_t e;
    zz = z;
    desel = d;
    e.exp = exp;
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic do_reset(input string tag);
    rst_ni = 1'b0;
    #1;
    compare(4'b0000, tag);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // drive into sleep from awake with no error; leaves block asleep
  task automatic enter_sleep(input logic [0:0] e);
    step(1, 1, {3'b000, e}, "R2");
    step(1, 1, {3'b001, e}, "R2");
    step(1, 1, {3'b011, e}, "R2");
    step(1, 1, {3'b011, e}, "R3");
    step(1, 1, {3'b111, e}, "R3");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    #1 compare(4'b0000, "R1");
    @(negedge clk);
    rst_ni = 1'b1;
    step(0, 1, 4'b0000, "R1");
    step(0, 0, 4'b0000, "R7");
    step(0, 1, 4'b0000, "R1");

    // full entry/exit with selects toggled while asleep
    enter_sleep(1'b0);
    step(1, 0, 4'b1110, "R4");
    step(1, 0, 4'b1110, "R7");
    step(1, 1, 4'b1110, "R4");
    step(0, 1, 4'b1110, "R5");
    step(0, 1, 4'b1110, "R5");
    step(0, 1, 4'b0110, "R5");
    step(0, 1, 4'b0110, "R5");
    step(0, 1, 4'b0000, "R5");
    step(0, 1, 4'b0000, "R7");

    // selection during recovery
    enter_sleep(1'b0);
    step(0, 1, 4'b1110, "R5");
    step(0, 1, 4'b1110, "R5");
    step(0, 1, 4'b0110, "R6");
    step(0, 0, 4'b0111, "R6");
    step(0, 1, 4'b0001, "R6");
    step(0, 1, 4'b0001, "R6");

    // reset while asleep with error set
    enter_sleep(1'b1);
    step(1, 1, 4'b1111, "R4");
    do_reset("R9");
    step(0, 1, 4'b0000, "R9");
    step(0, 1, 4'b0000, "R9");

    // single-cycle pulse
    step(1, 1, 4'b0000, "R8");
    step(0, 1, 4'b0010, "R8");
    step(0, 1, 4'b0110, "R8");
    step(0, 1, 4'b0110, "R8");
    step(0, 1, 4'b1110, "R8");
    step(0, 1, 4'b0110, "R8");
    step(0, 1, 4'b0110, "R8");
    step(0, 1, 4'b0000, "R8");
    step(0, 1, 4'b0000, "R8");

    @(negedge clk);
    @(negedge clk);
    if (sb_q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard left %0d expected %0d", sb_q.size(), 0);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule